// File: doc/BRIEF.md
# Coherent Processor Network Interface

This block sits between a processor core and the router injection port of a directory-coherent on-chip mesh. Local requests from the core (read, read-exclusive, eviction write) are turned into packet headers and kept in a source queue. Invalidation and write-back requests that arrive from home banks are handed to the private cache through a request/acknowledge handshake. Once the cache acknowledges, a reply (invalidation acknowledge or write-back data) is placed in a separate response queue. One scheduler drains both queues onto the single injection port under credit flow control.

The network gives short control messages a higher priority than data-carrying messages, so it may deliver them out of order. A control request can therefore overtake the data reply for a block the core is still waiting on. The interface keeps the address of its single outstanding read. Any invalidation or write-back request that hits that address is parked until the fill has reached the cache, and only then is it applied.

Top module: `coh_proc_nif`

## Requirements
- R1: After reset no packet is offered (`tx_valid_o` low), no cache operation is requested (`l1_req_o` low), the core request port is ready, and an arriving data reply would be accepted.
- R2: Each packet header is laid out from MSB to LSB as type[3], priority[1], source node[NODE_W], destination node[NODE_W], block address[ADDR_W]. The type codes are READ=0, READX=1, WRITE=2, INV=3, INV_ACK=4, WB_REQ=5, WB_DATA=6, RD_DATA=7. The source is NODE_ID. Priority is 1 for READ, READX, INV, INV_ACK and WB_REQ, and 0 for WRITE, WB_DATA and RD_DATA. Core requests (op 0=READ, 1=READX, 2=WRITE) leave in the order accepted, with destination equal to `cpu_req_home_i`.
- R3: When both queues hold a packet and a credit is available, the response queue is served first.
- R4: The interface starts with NUM_CREDITS credits. Each injected packet uses one and each `tx_credit_i` pulse returns one. No packet is offered while the count is zero.
- R5: After a READ or READX is injected, no further source-queue packet is sent until the matching RD_DATA has been accepted by the cache. Response packets are still sent meanwhile.
- R6: A WRITE does not stall the source queue; a following source packet may go out as soon as a credit allows.
- R7: An INV or WB_REQ whose address differs from the pending read is issued to the cache as op 1 (invalidate) or op 2 (write back); a RD_DATA is issued as op 0 (fill). After the cache acknowledges, INV_ACK or WB_DATA is queued with the request's source as destination and the same address.
- R8: An INV or WB_REQ that hits the pending read address is held and not shown to the cache. It is issued to the cache at the clock edge after the edge on which the fill is acknowledged.
- R9: While a control request is held, further INV and WB_REQ packets are refused (`rx_ready_o` low), but a RD_DATA is still accepted.
- R10: `cpu_req_ready_o` is low while the source queue holds SRC_DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_valid_i | input | 1 | Core request valid |
| cpu_req_ready_o | output | 1 | Source queue can take a request |
| cpu_req_op_i | input | 2 | 0 read, 1 read-exclusive, 2 eviction write |
| cpu_req_addr_i | input | ADDR_W | Block address |
| cpu_req_home_i | input | NODE_W | Home bank node |
| tx_valid_o | output | 1 | Packet injected this cycle |
| tx_pkt_o | output | PKT_W | Injected packet header |
| tx_credit_i | input | 1 | One router buffer freed |
| rx_valid_i | input | 1 | Arriving packet valid |
| rx_ready_o | output | 1 | Arriving packet accepted |
| rx_pkt_i | input | PKT_W | Arriving packet header |
| l1_req_o | output | 1 | Cache operation requested |
| l1_op_o | output | 2 | 0 fill, 1 invalidate, 2 write back |
| l1_addr_o | output | ADDR_W | Block address of the operation |
| l1_ack_i | input | 1 | Cache completed the operation |

## Verification
The fill acknowledgement for the outstanding read and the arrival of a conflicting invalidation are the two functions whose timing collide. The bench lets the read go out, then delivers the invalidation for the same block before the data reply. It also offers a second control request while the first is parked and expects it to be refused. From the cache log the bench judges the fill first, the deferred invalidate exactly two acknowledge edges later, and the acknowledge packet only after that. Response-over-source arbitration is provoked by starving credits while both queues fill, then granting a single credit and checking which packet leaves.

// File: rtl/coh_nif_pkg.sv
package coh_nif_pkg;

  typedef enum logic [2:0] {
    MSG_READ    = 3'd0,
    MSG_READX   = 3'd1,
    MSG_WRITE   = 3'd2,
    MSG_INV     = 3'd3,
    MSG_INV_ACK = 3'd4,
    MSG_WB_REQ  = 3'd5,
    MSG_WB_DATA = 3'd6,
    MSG_RD_DATA = 3'd7
  } msg_e;

  typedef enum logic [1:0] {
    L1_FILL = 2'd0,
    L1_INV  = 2'd1,
    L1_WB   = 2'd2
  } l1_op_e;

  localparam int MSG_W = 3;

  // data-free messages travel on the high-priority class
  function automatic logic msg_prio(msg_e t);
    return !(t == MSG_WRITE || t == MSG_WB_DATA || t == MSG_RD_DATA);
  endfunction

  function automatic logic msg_opens_read(msg_e t);
    return (t == MSG_READ) || (t == MSG_READX);
  endfunction

endpackage

// File: rtl/coh_nif_fifo.sv
module coh_nif_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_next(wr_q);
      if (pop_i)  rd_q <= ptr_next(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  a_r10_push_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r2_pop_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

endmodule

// File: rtl/coh_nif_sched.sv
module coh_nif_sched
  import coh_nif_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ENT_W       = 23,
  parameter int NUM_CREDITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_empty_i,
  input  logic [ENT_W-1:0]  rsp_head_i,
  input  logic              src_empty_i,
  input  logic [ENT_W-1:0]  src_head_i,
  input  logic              credit_i,
  input  logic              fill_done_i,
  output logic              rsp_pop_o,
  output logic              src_pop_o,
  output logic              tx_valid_o,
  output logic [ENT_W-1:0]  tx_ent_o,
  output logic              pend_valid_o,
  output logic [ADDR_W-1:0] pend_addr_o
);
  localparam int CRW = $clog2(NUM_CREDITS + 1);

  logic [CRW-1:0]    crd_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              has_crd;
  msg_e              src_type;

  assign has_crd  = (crd_q != '0);
  assign src_type = msg_e'(src_head_i[ENT_W-1 -: MSG_W]);

  // response queue first: replies must drain or the protocol can deadlock
  assign rsp_pop_o  = !rsp_empty_i && has_crd;
  assign src_pop_o  = !rsp_pop_o && !src_empty_i && !pend_q && has_crd;
  assign tx_valid_o = rsp_pop_o || src_pop_o;
  assign tx_ent_o   = rsp_pop_o ? rsp_head_i : src_head_i;

  assign pend_valid_o = pend_q;
  assign pend_addr_o  = pend_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crd_q       <= CRW'(NUM_CREDITS);
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      crd_q <= crd_q - CRW'(tx_valid_o) + CRW'(credit_i);
      if (fill_done_i) pend_q <= 1'b0;
      if (src_pop_o && msg_opens_read(src_type)) begin
        pend_q      <= 1'b1;
        pend_addr_q <= src_head_i[ADDR_W-1:0];
      end
    end
  end

  a_r4_credit_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crd_q <= CRW'(NUM_CREDITS));
  a_r5_pend_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !fill_done_i |=> pend_q && $stable(pend_addr_q));

endmodule

// File: rtl/coh_nif_rx.sv
module coh_nif_rx
  import coh_nif_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NODE_W = 4,
  parameter int ENT_W  = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  msg_e              rx_type_i,
  input  logic [NODE_W-1:0] rx_src_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  output logic              rx_ready_o,
  input  logic              pend_valid_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  logic              rsp_full_i,
  output logic              rsp_push_o,
  output logic [ENT_W-1:0]  rsp_ent_o,
  output logic              fill_done_o,
  output logic              l1_req_o,
  output logic [1:0]        l1_op_o,
  output logic [ADDR_W-1:0] l1_addr_o,
  input  logic              l1_ack_i
);
  logic              busy_q, def_q;
  l1_op_e            cur_op_q, def_op_q, rx_op;
  logic [NODE_W-1:0] cur_src_q, def_src_q;
  logic [ADDR_W-1:0] cur_addr_q, def_addr_q;
  logic              rx_data, rx_ctrl, hit, accept, done;
  logic              release_pend, release_go;
  msg_e              rsp_type;

  assign rx_data = (rx_type_i == MSG_RD_DATA);
  assign rx_ctrl = (rx_type_i == MSG_INV) || (rx_type_i == MSG_WB_REQ);
  assign rx_op   = rx_data ? L1_FILL : ((rx_type_i == MSG_WB_REQ) ? L1_WB : L1_INV);
  // control request overtook the data reply of our own pending read
  assign hit     = rx_ctrl && pend_valid_i && (rx_addr_i == pend_addr_i);

  assign release_pend = def_q && !pend_valid_i;
  assign release_go   = release_pend && !busy_q && !rsp_full_i;

  always_comb begin
    rx_ready_o = 1'b0;
    if (!busy_q && !release_pend) begin
      if (rx_ctrl) rx_ready_o = !def_q && !rsp_full_i;
      else         rx_ready_o = 1'b1;
    end
  end

  assign accept = rx_valid_i && rx_ready_o;
  assign done   = busy_q && l1_ack_i;

  assign fill_done_o = done && (cur_op_q == L1_FILL);
  assign rsp_push_o  = done && (cur_op_q != L1_FILL);
  assign rsp_type    = (cur_op_q == L1_WB) ? MSG_WB_DATA : MSG_INV_ACK;
  assign rsp_ent_o   = {rsp_type, cur_src_q, cur_addr_q};

  assign l1_req_o  = busy_q;
  assign l1_op_o   = cur_op_q;
  assign l1_addr_o = cur_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cur_op_q   <= L1_FILL;
      cur_src_q  <= '0;
      cur_addr_q <= '0;
      def_q      <= 1'b0;
      def_op_q   <= L1_INV;
      def_src_q  <= '0;
      def_addr_q <= '0;
    end else begin
      if (done) busy_q <= 1'b0;
      if (release_go) begin
        busy_q     <= 1'b1;
        cur_op_q   <= def_op_q;
        cur_src_q  <= def_src_q;
        cur_addr_q <= def_addr_q;
        def_q      <= 1'b0;
      end else if (accept) begin
        if (hit) begin
          def_q      <= 1'b1;
          def_op_q   <= rx_op;
          def_src_q  <= rx_src_i;
          def_addr_q <= rx_addr_i;
        end else if (rx_data || rx_ctrl) begin
          busy_q     <= 1'b1;
          cur_op_q   <= rx_op;
          cur_src_q  <= rx_src_i;
          cur_addr_q <= rx_addr_i;
        end
      end
    end
  end

  a_r8_no_early_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_req_o && (l1_op_o != L1_FILL) |-> !(pend_valid_i && (l1_addr_o == pend_addr_i)));
  a_r8_def_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    def_q && pend_valid_i |=> def_q);
  a_r7_l1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_req_o && !l1_ack_i |=> l1_req_o && $stable(l1_addr_o) && $stable(l1_op_o));

endmodule

// File: rtl/coh_proc_nif.sv
module coh_proc_nif
  import coh_nif_pkg::*;
#(
  parameter int NODE_W      = 4,
  parameter int ADDR_W      = 16,
  parameter int NODE_ID     = 3,
  parameter int SRC_DEPTH   = 4,
  parameter int RSP_DEPTH   = 2,
  parameter int NUM_CREDITS = 2,
  localparam int PKT_W      = MSG_W + 1 + 2 * NODE_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic [1:0]        cpu_req_op_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  input  logic [NODE_W-1:0] cpu_req_home_i,
  output logic              tx_valid_o,
  output logic [PKT_W-1:0]  tx_pkt_o,
  input  logic              tx_credit_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [PKT_W-1:0]  rx_pkt_i,
  output logic              l1_req_o,
  output logic [1:0]        l1_op_o,
  output logic [ADDR_W-1:0] l1_addr_o,
  input  logic              l1_ack_i
);
  localparam int ENT_W = MSG_W + NODE_W + ADDR_W;
  localparam logic [NODE_W-1:0] MY_ID = NODE_W'(NODE_ID);

  logic              src_full, src_empty, src_pop, src_push;
  logic [ENT_W-1:0]  src_in, src_head;
  logic              rsp_full, rsp_empty, rsp_pop, rsp_push;
  logic [ENT_W-1:0]  rsp_in, rsp_head;
  logic [ENT_W-1:0]  tx_ent;
  logic              pend_valid, fill_done;
  logic [ADDR_W-1:0] pend_addr;
  msg_e              tx_type, rx_type;
  logic [NODE_W-1:0] rx_src, rx_dst;
  logic [ADDR_W-1:0] rx_addr;
  logic              rx_prio;

  assign cpu_req_ready_o = !src_full;
  assign src_push        = cpu_req_valid_i && !src_full;
  assign src_in          = {msg_e'({1'b0, cpu_req_op_i}), cpu_req_home_i, cpu_req_addr_i};

  coh_nif_fifo #(.W(ENT_W), .DEPTH(SRC_DEPTH)) u_src_q (
    .clk_i, .rst_ni,
    .push_i(src_push), .data_i(src_in), .full_o(src_full),
    .pop_i(src_pop), .data_o(src_head), .empty_o(src_empty)
  );

  coh_nif_fifo #(.W(ENT_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk_i, .rst_ni,
    .push_i(rsp_push), .data_i(rsp_in), .full_o(rsp_full),
    .pop_i(rsp_pop), .data_o(rsp_head), .empty_o(rsp_empty)
  );

  coh_nif_sched #(.ADDR_W(ADDR_W), .ENT_W(ENT_W), .NUM_CREDITS(NUM_CREDITS)) u_sched (
    .clk_i, .rst_ni,
    .rsp_empty_i(rsp_empty), .rsp_head_i(rsp_head),
    .src_empty_i(src_empty), .src_head_i(src_head),
    .credit_i(tx_credit_i), .fill_done_i(fill_done),
    .rsp_pop_o(rsp_pop), .src_pop_o(src_pop),
    .tx_valid_o(tx_valid_o), .tx_ent_o(tx_ent),
    .pend_valid_o(pend_valid), .pend_addr_o(pend_addr)
  );

  assign tx_type  = msg_e'(tx_ent[ENT_W-1 -: MSG_W]);
  assign tx_pkt_o = {tx_type, msg_prio(tx_type), MY_ID, tx_ent[ENT_W-MSG_W-1:0]};

  assign rx_type = msg_e'(rx_pkt_i[PKT_W-1 -: MSG_W]);
  assign rx_prio = rx_pkt_i[PKT_W-MSG_W-1];
  assign rx_src  = rx_pkt_i[ADDR_W + 2*NODE_W - 1 -: NODE_W];
  assign rx_dst  = rx_pkt_i[ADDR_W + NODE_W - 1 -: NODE_W];
  assign rx_addr = rx_pkt_i[ADDR_W-1:0];

  coh_nif_rx #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .ENT_W(ENT_W)) u_rx (
    .clk_i, .rst_ni,
    .rx_valid_i, .rx_type_i(rx_type), .rx_src_i(rx_src), .rx_addr_i(rx_addr),
    .rx_ready_o,
    .pend_valid_i(pend_valid), .pend_addr_i(pend_addr),
    .rsp_full_i(rsp_full), .rsp_push_o(rsp_push), .rsp_ent_o(rsp_in),
    .fill_done_o(fill_done),
    .l1_req_o, .l1_op_o, .l1_addr_o, .l1_ack_i
  );

  a_r3_rsp_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && (tx_type inside {MSG_READ, MSG_READX, MSG_WRITE}) |-> rsp_empty);
  a_r5_no_src_while_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && msg_opens_read(tx_type) |=> pend_valid);
  a_r2_cpu_op_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_valid_i |-> cpu_req_op_i != 2'd3);
  a_r2_rx_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> (rx_dst == MY_ID) && (rx_prio == msg_prio(rx_type)));

endmodule

// File: tb/coh_proc_nif_tb_top.sv
module coh_proc_nif_tb_top;
  localparam int NODE_W = 4;
  localparam int ADDR_W = 16;
  localparam int NID    = 3;
  localparam int PKT_W  = 3 + 1 + 2 * NODE_W + ADDR_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic              cpu_req_valid_i = 1'b0;
  logic              cpu_req_ready_o;
  logic [1:0]        cpu_req_op_i = '0;
  logic [ADDR_W-1:0] cpu_req_addr_i = '0;
  logic [NODE_W-1:0] cpu_req_home_i = '0;
  logic              tx_valid_o;
  logic [PKT_W-1:0]  tx_pkt_o;
  logic              tx_credit_i;
  logic              rx_valid_i = 1'b0;
  logic              rx_ready_o;
  logic [PKT_W-1:0]  rx_pkt_i;
  logic              l1_req_o;
  logic [1:0]        l1_op_o;
  logic [ADDR_W-1:0] l1_addr_o;
  logic              l1_ack_i = 1'b0;

  coh_proc_nif #(.NODE_W(NODE_W), .ADDR_W(ADDR_W), .NODE_ID(NID),
                 .SRC_DEPTH(4), .RSP_DEPTH(2), .NUM_CREDITS(2)) dut_i (
    .clk_i(clk), .rst_ni,
    .cpu_req_valid_i, .cpu_req_ready_o, .cpu_req_op_i, .cpu_req_addr_i, .cpu_req_home_i,
    .tx_valid_o, .tx_pkt_o, .tx_credit_i,
    .rx_valid_i, .rx_ready_o, .rx_pkt_i,
    .l1_req_o, .l1_op_o, .l1_addr_o, .l1_ack_i
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  // router model: logs packets and returns credits
  logic [PKT_W-1:0] tx_log [64];
  int  tx_cyc [64];
  int  tx_n = 0;
  bit  credit_auto = 1;
  logic ret_q = 1'b0;
  logic man_credit = 1'b0;
  int  owed = 0;
  assign tx_credit_i = ret_q | man_credit;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ret_q <= tx_valid_o && credit_auto;
    if (tx_valid_o && !credit_auto) owed = owed + 1;
    if (man_credit) owed = owed - 1;
    if (tx_valid_o && tx_n < 64) begin
      tx_log[tx_n] = tx_pkt_o;
      tx_cyc[tx_n] = cyc;
      tx_n = tx_n + 1;
    end
  end

  // cache model: acknowledges each request one cycle after it appears
  logic [1:0]        l1_op_log [64];
  logic [ADDR_W-1:0] l1_addr_log [64];
  int                l1_cyc_log [64];
  int                l1_n = 0;

  always @(negedge clk) l1_ack_i <= l1_req_o && !l1_ack_i;

  always @(posedge clk) begin
    if (l1_req_o && l1_ack_i && l1_n < 64) begin
      l1_op_log[l1_n]   = l1_op_o;
      l1_addr_log[l1_n] = l1_addr_o;
      l1_cyc_log[l1_n]  = cyc;
      l1_n = l1_n + 1;
    end
  end

  function automatic logic [2:0] f_type(logic [PKT_W-1:0] p); return p[PKT_W-1 -: 3]; endfunction
  function automatic logic f_prio(logic [PKT_W-1:0] p); return p[PKT_W-4]; endfunction
  function automatic logic [NODE_W-1:0] f_src(logic [PKT_W-1:0] p); return p[ADDR_W+2*NODE_W-1 -: NODE_W]; endfunction
  function automatic logic [NODE_W-1:0] f_dst(logic [PKT_W-1:0] p); return p[ADDR_W+NODE_W-1 -: NODE_W]; endfunction
  function automatic logic [ADDR_W-1:0] f_addr(logic [PKT_W-1:0] p); return p[ADDR_W-1:0]; endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  task automatic chk_pkt(input string req, input int idx, input logic [2:0] t,
                         input logic pr, input logic [NODE_W-1:0] d, input logic [ADDR_W-1:0] a);
    chk_eq(req, "pkt type",  32'(f_type(tx_log[idx])), 32'(t));
    chk_eq(req, "pkt prio",  32'(f_prio(tx_log[idx])), 32'(pr));
    chk_eq(req, "pkt src",   32'(f_src(tx_log[idx])),  32'(NID));
    chk_eq(req, "pkt dst",   32'(f_dst(tx_log[idx])),  32'(d));
    chk_eq(req, "pkt addr",  32'(f_addr(tx_log[idx])), 32'(a));
  endtask

  task automatic push_cpu(input logic [1:0] op, input logic [ADDR_W-1:0] a, input logic [NODE_W-1:0] h);
    @(negedge clk);
    cpu_req_valid_i = 1'b1; cpu_req_op_i = op; cpu_req_addr_i = a; cpu_req_home_i = h;
    #1;
    while (!cpu_req_ready_o) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cpu_req_valid_i = 1'b0;
  endtask

  function automatic logic [PKT_W-1:0] mk_rx(input logic [2:0] t, input logic [NODE_W-1:0] s,
                                              input logic [ADDR_W-1:0] a);
    logic pr;
    pr = (t == 3'd3) || (t == 3'd5);
    return {t, pr, s, NODE_W'(NID), a};
  endfunction

  task automatic rx_send(input logic [2:0] t, input logic [NODE_W-1:0] s, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    rx_pkt_i = mk_rx(t, s, a); rx_valid_i = 1'b1;
    #1;
    while (!rx_ready_o) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    rx_valid_i = 1'b0;
    rx_pkt_i = mk_rx(3'd7, 0, 0);
  endtask

  task automatic wait_tx(input int n);
    for (int i = 0; i < 60 && tx_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_l1(input int n);
    for (int i = 0; i < 60 && l1_n < n; i++) @(negedge clk);
  endtask

  task automatic give_credit();
    @(negedge clk); man_credit = 1'b1;
    @(negedge clk); man_credit = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk_eq("R1", "tx_valid",  32'(tx_valid_o), 0);
    chk_eq("R1", "l1_req",    32'(l1_req_o), 0);
    chk_eq("R1", "cpu_ready", 32'(cpu_req_ready_o), 1);
    chk_eq("R1", "rx_ready",  32'(rx_ready_o), 1);
  endtask

  task automatic t_writes();
    int b = tx_n;
    push_cpu(2'd2, 16'h1234, 4'd5);
    push_cpu(2'd2, 16'h0042, 4'd9);
    wait_tx(b + 2);
    chk_eq("R6", "writes sent", 32'(tx_n), 32'(b + 2));
    chk_pkt("R2", b,     3'd2, 1'b0, 4'd5, 16'h1234);
    chk_pkt("R2", b + 1, 3'd2, 1'b0, 4'd9, 16'h0042);
  endtask

  task automatic t_read_stall();
    int b = tx_n;
    int lb = l1_n;
    push_cpu(2'd0, 16'h0100, 4'd2);
    push_cpu(2'd2, 16'h0200, 4'd2);
    repeat (10) @(negedge clk);
    chk_eq("R5", "only read sent", 32'(tx_n), 32'(b + 1));
    chk_pkt("R2", b, 3'd0, 1'b1, 4'd2, 16'h0100);
    rx_send(3'd7, 4'd2, 16'h0100);
    wait_l1(lb + 1);
    chk_eq("R7", "fill op",   32'(l1_op_log[lb]), 0);
    chk_eq("R7", "fill addr", 32'(l1_addr_log[lb]), 32'h0100);
    wait_tx(b + 2);
    chk_pkt("R5", b + 1, 3'd2, 1'b0, 4'd2, 16'h0200);
    chk("R5", "write after fill ack", tx_cyc[b + 1] > l1_cyc_log[lb], tx_cyc[b + 1], l1_cyc_log[lb]);
  endtask

  task automatic t_ctrl();
    int b = tx_n;
    int lb = l1_n;
    rx_send(3'd3, 4'd7, 16'h0300);
    wait_tx(b + 1);
    chk_eq("R7", "inv op", 32'(l1_op_log[lb]), 1);
    chk_eq("R7", "inv addr", 32'(l1_addr_log[lb]), 32'h0300);
    chk_pkt("R7", b, 3'd4, 1'b1, 4'd7, 16'h0300);
    rx_send(3'd5, 4'd8, 16'h0400);
    wait_tx(b + 2);
    chk_eq("R7", "wb op", 32'(l1_op_log[lb + 1]), 2);
    chk_pkt("R7", b + 1, 3'd6, 1'b0, 4'd8, 16'h0400);
  endtask

  task automatic t_credits();
    int b;
    credit_auto = 0;
    repeat (3) @(negedge clk);
    b = tx_n;
    push_cpu(2'd2, 16'h0A01, 4'd1);
    push_cpu(2'd2, 16'h0A02, 4'd1);
    for (int k = 3; k <= 6; k++) push_cpu(2'd2, ADDR_W'(16'h0A00 + k), 4'd1);
    @(negedge clk); #1;
    chk_eq("R10", "cpu_ready full", 32'(cpu_req_ready_o), 0);
    chk_eq("R4", "sent on 2 credits", 32'(tx_n), 32'(b + 2));
    rx_send(3'd3, 4'd1, 16'h0500);
    repeat (5) @(negedge clk);
    chk_eq("R4", "no credit no tx", 32'(tx_n), 32'(b + 2));
    give_credit();
    wait_tx(b + 3);
    chk_eq("R3", "rsp before src", 32'(f_type(tx_log[b + 2])), 4);
    give_credit();
    wait_tx(b + 4);
    chk_eq("R2", "order kept", 32'(f_addr(tx_log[b + 3])), 32'h0A03);
    @(negedge clk); #1;
    chk_eq("R10", "cpu_ready after pop", 32'(cpu_req_ready_o), 1);
    for (int i = 0; i < 20 && tx_n < b + 7; i++) give_credit();
    chk_eq("R4", "drained", 32'(tx_n), 32'(b + 7));
    for (int i = 0; i < 20 && owed > 0; i++) give_credit();
    credit_auto = 1;
  endtask

  task automatic t_defer();
    int b = tx_n;
    int lb = l1_n;
    push_cpu(2'd1, 16'h0600, 4'd4);
    wait_tx(b + 1);
    chk_pkt("R2", b, 3'd1, 1'b1, 4'd4, 16'h0600);
    rx_send(3'd3, 4'd4, 16'h0600);
    repeat (4) @(negedge clk);
    chk_eq("R8", "inv held from cache", 32'(l1_n), 32'(lb));
    chk_eq("R8", "no early ack", 32'(tx_n), 32'(b + 1));
    @(negedge clk);
    rx_pkt_i = mk_rx(3'd5, 4'd5, 16'h0700); rx_valid_i = 1'b1;
    #1;
    chk_eq("R9", "2nd ctrl refused", 32'(rx_ready_o), 0);
    repeat (3) @(negedge clk);
    #1;
    chk_eq("R9", "still refused", 32'(rx_ready_o), 0);
    rx_valid_i = 1'b0;
    rx_pkt_i = mk_rx(3'd7, 4'd4, 16'h0600);
    #1;
    chk_eq("R9", "data accepted", 32'(rx_ready_o), 1);
    rx_send(3'd7, 4'd4, 16'h0600);
    wait_l1(lb + 2);
    chk_eq("R8", "fill first", 32'(l1_op_log[lb]), 0);
    chk_eq("R8", "inv second", 32'(l1_op_log[lb + 1]), 1);
    chk_eq("R8", "inv addr", 32'(l1_addr_log[lb + 1]), 32'h0600);
    chk_eq("R8", "release timing", 32'(l1_cyc_log[lb + 1] - l1_cyc_log[lb]), 2);
    wait_tx(b + 2);
    chk_pkt("R8", b + 1, 3'd4, 1'b1, 4'd4, 16'h0600);
    rx_send(3'd5, 4'd5, 16'h0700);
    wait_tx(b + 3);
    chk_pkt("R9", b + 2, 3'd6, 1'b0, 4'd5, 16'h0700);
  endtask

  initial begin
    rx_pkt_i = mk_rx(3'd7, 0, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_writes();
    t_read_stall();
    t_ctrl();
    t_credits();
    t_defer();
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule